// File: doc/BRIEF.md
# Windowed Watchdog with Write-Once Keyed Setup

This block supervises software that must prove it is alive at a controlled pace. A service that arrives too late is a fault. A service that arrives too soon after the previous one is also a fault. All software access goes through one 8-bit write port. The first write after reset that carries the correct key pattern fixes the window choice and a clock-monitor enable flag, and nothing can change them again until the next reset. From then on, every write is compared in full against the stored byte. An exact match is a service and anything else is a fault.

When a fault occurs, the block pulls an active-low, open-drain-style output low. It keeps pulling until the sensed level of that pin reads low, and then for a fixed number of further cycles. It then lets go and waits for the sensed level to return high before a fresh window begins. A boot-entry pulse gives an immediate service that is exempt from the lower limit. The write port is a single-cycle strobe that is always taken. There is no back-pressure: `wr_en` has no ready partner, and a write arriving in a state that ignores it is simply dropped.

Top module: `wdt_windowed`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: `wdout_n`=1, `cfg_done`=0, `win_sel`=2'b11, `clkmon_en`=1 and `fault_act`=0.
- R2: While `cfg_done`=0, a write whose bits 5:1 equal 5'b01100 is the configuring write. It stores all 8 bits (bits 7:6 appear on `win_sel`, bit 0 on `clkmon_en`), sets `cfg_done` permanently, and restarts the window without any lower-limit check.
- R3: While `cfg_done`=0, a write whose bits 5:1 differ from 5'b01100 raises a fault, and `cfg_done` stays 0.
- R4: Once `cfg_done`=1, a write equal to all 8 stored bits is a service. Any other value raises a fault and leaves `win_sel` and `clkmon_en` unchanged.
- R5: Window code w gives a lower limit L = LO_BASE·2^w and an upper limit U = L·RATIO. If no service is sampled within U edges of the window start, `wdout_n` goes low after the U-th edge. A service sampled on edge U is on time.
- R6: A service sampled fewer than L edges after the previous service or configuring write raises a fault. A service exactly L edges later does not. The first service after reset, after fault recovery or after a boot pulse has no lower limit.
- R7: A fault drives `wdout_n` low from the edge after it is detected. It stays low until `pin_lvl` is sampled low, then for HOLD_CYC further cycles, and is then released. With `pin_lvl` following the pin, that is HOLD_CYC+1 low cycles.
- R8: `fault_act` is 1 from the fault until `pin_lvl` is sampled high after release. That edge starts a new window (edge 0).
- R9: Writes sampled while `fault_act`=1 are ignored: they cause no fault, no service and no configuration.
- R10: A `boot_entry` pulse sampled while `fault_act`=0 is an immediate service: the window restarts and no lower limit applies to it or to the next service. A write on the same edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data: [7:6] window, [5:1] key, [0] clock-monitor enable |
| pin_lvl | input | 1 | Sensed digital level of the fault pin |
| boot_entry | input | 1 | Boot-mode entry pulse |
| wdout_n | output | 1 | Fault pin drive, 0 = pull low, 1 = release |
| cfg_done | output | 1 | Configuring write has been accepted |
| clkmon_en | output | 1 | Stored clock-monitor enable bit |
| win_sel | output | 2 | Stored window code |
| fault_act | output | 1 | Fault sequence in progress |

## Verification
Each of the four window codes is swept from a fresh reset. Services are placed at spacings of L−1, L and U, and a silent stretch probes the late limit, so an off-by-one at either bound shows up as a fault on the wrong edge. Writes that differ from the stored byte in a single bit, writes with a wrong key, writes landing during a fault and a write that coincides with a boot pulse separate a real service from an ignored or faulting write. The pin level is held high or low by force during fault sequences, which shows whether release waits on the sensed level rather than on time alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_PULL, ST_HOLD, ST_REL} wdt_st_e;

  typedef struct packed {
    logic [1:0] win;
    logic [4:0] key;
    logic       cmon;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_keyreg.sv
module wdt_keyreg
  import wdt_pkg::*;
#(
  parameter logic [4:0] KEY = 5'b01100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output wdt_cfg_t   cfg,
  output logic       cfg_done,
  output logic       cfg_wr,
  output logic       svc_ok,
  output logic       bad_wr
);
  logic wr_act, key_ok, match;

  assign wr_act = accept & wr_en;
  assign key_ok = (wr_data[5:1] == KEY);
  assign match  = (wr_data == cfg);
  assign cfg_wr = wr_act & ~cfg_done & key_ok;
  assign svc_ok = wr_act & cfg_done & match;
  assign bad_wr = wr_act & ((~cfg_done & ~key_ok) | (cfg_done & ~match));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '{win: 2'b11, key: KEY, cmon: 1'b1};
      cfg_done <= 1'b0;
    end else if (cfg_wr) begin
      cfg      <= wdt_cfg_t'(wr_data);
      cfg_done <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int LO_BASE = 4,
  parameter int RATIO   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] win,
  input  logic       svc,
  input  logic       arm_svc,
  input  logic       boot,
  output logic       early,
  output logic       late
);
  localparam int UP_MAX = (LO_BASE << 3) * RATIO;
  localparam int CW     = $clog2(UP_MAX + 1) + 1;

  logic [CW-1:0] lo_tab [4];
  logic [CW-1:0] up_tab [4];
  logic [CW-1:0] cnt, lo_sel, up_sel;
  logic          armed;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lo_tab[g] = CW'(LO_BASE << g);
    assign up_tab[g] = CW'((LO_BASE << g) * RATIO);
  end

  assign lo_sel = lo_tab[win];
  assign up_sel = up_tab[win];
  assign early  = run & svc & armed & (cnt < lo_sel);
  assign late   = run & ~svc & ~arm_svc & ~boot & (cnt >= up_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= CW'(1);
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= CW'(1);
      armed <= 1'b0;
    end else if (run) begin
      if (boot) begin
        cnt   <= CW'(1);
        armed <= 1'b0;
      end else if (svc | arm_svc) begin
        cnt   <= CW'(1);
        armed <= 1'b1;
      end else if (cnt != '1) begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_fault.sv
module wdt_fault
  import wdt_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic pin_lvl,
  output logic run,
  output logic restart,
  output logic drive_low
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  wdt_st_e       st;
  logic [HW-1:0] hc;

  assign run       = (st == ST_RUN);
  assign drive_low = (st == ST_PULL) | (st == ST_HOLD);
  assign restart   = (st == ST_REL) & pin_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_RUN;
      hc <= '0;
    end else begin
      unique case (st)
        ST_RUN:  if (trip) st <= ST_PULL;
        ST_PULL: if (!pin_lvl) begin
                   st <= ST_HOLD;
                   hc <= '0;
                 end
        ST_HOLD: if (hc == HW'(HOLD_CYC - 1)) st <= ST_REL;
                 else hc <= hc + HW'(1);
        ST_REL:  if (pin_lvl) st <= ST_RUN;
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
  import wdt_pkg::*;
#(
  parameter logic [4:0] KEY      = 5'b01100,
  parameter int         LO_BASE  = 4,
  parameter int         RATIO    = 8,
  parameter int         HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       pin_lvl,
  input  logic       boot_entry,
  output logic       wdout_n,
  output logic       cfg_done,
  output logic       clkmon_en,
  output logic [1:0] win_sel,
  output logic       fault_act
);
  wdt_cfg_t cfg;
  logic run, restart, drive_low;
  logic cfg_wr, svc_ok, bad_wr, early, late, boot;

  assign boot = run & boot_entry;

  wdt_keyreg #(.KEY(KEY)) u_key (
    .clk(clk), .rst_n(rst_n), .accept(run & ~boot_entry),
    .wr_en(wr_en), .wr_data(wr_data), .cfg(cfg), .cfg_done(cfg_done),
    .cfg_wr(cfg_wr), .svc_ok(svc_ok), .bad_wr(bad_wr)
  );

  wdt_window #(.LO_BASE(LO_BASE), .RATIO(RATIO)) u_win (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .win(cfg.win),
    .svc(svc_ok), .arm_svc(cfg_wr), .boot(boot), .early(early), .late(late)
  );

  wdt_fault #(.HOLD_CYC(HOLD_CYC)) u_flt (
    .clk(clk), .rst_n(rst_n), .trip(early | late | bad_wr),
    .pin_lvl(pin_lvl), .run(run), .restart(restart), .drive_low(drive_low)
  );

  assign wdout_n   = ~drive_low;
  assign fault_act = ~run;
  assign clkmon_en = cfg.cmon;
  assign win_sel   = cfg.win;
endmodule

// File: rtl/wdt_windowed_chk.sv
module wdt_windowed_chk #(
  parameter logic [4:0] KEY = 5'b01100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       pin_lvl,
  input logic       boot_entry,
  input logic       wdout_n,
  input logic       cfg_done,
  input logic       clkmon_en,
  input logic [1:0] win_sel,
  input logic       fault_act
);
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_done |=> cfg_done); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) cfg_done |=> ($stable(win_sel) && $stable(clkmon_en))); // R4
  AST_MISMATCH_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_act && wr_en && !boot_entry && cfg_done && wr_data != {win_sel, KEY, clkmon_en}) |=> !wdout_n); // R4
  AST_BADKEY_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_act && wr_en && !boot_entry && !cfg_done && wr_data[5:1] != KEY) |=> (!wdout_n && !cfg_done)); // R3
  AST_FAULT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (fault_act && wr_en) |=> $stable(cfg_done)); // R9
  AST_RUN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !fault_act |-> wdout_n); // R7
  AST_PULL_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(wdout_n) |=> !wdout_n); // R7
  AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (fault_act && wdout_n && !pin_lvl) |=> fault_act); // R8
endmodule

bind wdt_windowed wdt_windowed_chk #(.KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pin_lvl(pin_lvl),
  .boot_entry(boot_entry), .wdout_n(wdout_n), .cfg_done(cfg_done),
  .clkmon_en(clkmon_en), .win_sel(win_sel), .fault_act(fault_act)
);

// File: tb/wdt_windowed_bench.sv
module wdt_windowed_bench;
  localparam int HOLD = 16;
  localparam int LOB  = 4;
  localparam int RAT  = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, boot_entry = 0;
  logic [7:0] wr_data = '0;
  logic force_hi = 0, force_lo = 0;
  logic wdout_n, cfg_done, clkmon_en, fault_act, pin_lvl;
  logic [1:0] win_sel;
  int n_chk = 0, n_bad = 0, cyc = 0;

  assign pin_lvl = force_hi ? 1'b1 : (force_lo ? 1'b0 : wdout_n);

  wdt_windowed u_wdt_windowed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pin_lvl(pin_lvl),
    .boot_entry(boot_entry), .wdout_n(wdout_n), .cfg_done(cfg_done),
    .clkmon_en(clkmon_en), .win_sel(win_sel), .fault_act(fault_act)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic boot_pulse(logic with_wr, logic [7:0] d);
    boot_entry = 1; wr_en = with_wr; wr_data = d;
    @(posedge clk); @(negedge clk);
    boot_entry = 0; wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; force_hi = 0; force_lo = 0;
    tick(2);
    check("R1 wdout_n in reset", int'(wdout_n), 1);
    rst_n = 1;
  endtask

  // called at the negedge right after the fault edge; leaves at the negedge after the restart edge
  task automatic recover(string req);
    int low = 0;
    while (!wdout_n && low < 1000) begin low++; tick(1); end
    check({req, " R7 low cycles"}, low, HOLD + 1);
    check({req, " R8 still in fault before pin high"}, int'(fault_act), 1);
    tick(1);
    check({req, " R8 new window after pin high"}, int'(fault_act), 0);
  endtask

  initial begin
    @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      automatic int lo = LOB << w;
      automatic int up = lo * RAT;
      automatic logic [7:0] cv = {w[1:0], 5'b01100, w[0]};
      do_reset();
      check("R1 cfg_done", int'(cfg_done), 0);
      check("R1 win_sel", int'(win_sel), 3);
      check("R1 clkmon_en", int'(clkmon_en), 1);
      check("R1 fault_act", int'(fault_act), 0);
      tick(1); wr(cv);                      // configuring write at edge 2, free of lower limit
      check("R2 cfg_done", int'(cfg_done), 1);
      check("R2 win_sel", int'(win_sel), w);
      check("R2 clkmon_en", int'(clkmon_en), int'(w[0]));
      check("R2 no fault", int'(wdout_n), 1);
      tick(lo - 1); wr(cv);
      check("R6 service at L", int'(wdout_n), 1);
      tick(up - 1); wr(cv);
      check("R5 service at U", int'(wdout_n), 1);
      tick(lo - 2); wr(cv);
      check("R6 service at L-1 faults", int'(wdout_n), 0);
      check("R6 fault_act", int'(fault_act), 1);
      recover("early");
      tick(up - 1);
      check("R5 no fault at U-1", int'(wdout_n), 1);
      tick(1);
      check("R5 late fault after U", int'(wdout_n), 0);
      recover("late");
      tick(1); wr(cv);
      check("R6 first service after recovery is free", int'(wdout_n), 1);
      tick(lo); wr(cv ^ 8'h01);
      check("R4 one-bit mismatch faults", int'(wdout_n), 0);
      check("R4 clkmon_en kept", int'(clkmon_en), int'(w[0]));
      recover("mismatch");
      tick(lo); wr(cv);
      boot_pulse(1'b0, 8'h00);
      check("R10 boot right after service", int'(wdout_n), 1);
      wr(cv);
      check("R10 next service free after boot", int'(wdout_n), 1);
      wr(cv);
      check("R6 back-to-back service faults", int'(wdout_n), 0);
      recover("boot-early");
      tick(lo); wr(cv);
      boot_pulse(1'b1, 8'h5A);
      check("R10 write with boot ignored", int'(wdout_n), 1);
      tick(up - 1);
      check("R10 window restarted by boot, U-1", int'(wdout_n), 1);
      tick(1);
      check("R10 late after boot", int'(wdout_n), 0);
      recover("boot-late");
    end

    // default window 3 without any write: late at U = 256
    do_reset();
    tick(255);
    check("R5 default window U-1", int'(wdout_n), 1);
    tick(1);
    check("R5 default window late", int'(wdout_n), 0);
    recover("default");

    // wrong key, writes during fault, pin held high then low
    do_reset();
    tick(3); wr(8'hFF);
    check("R3 bad key faults", int'(wdout_n), 0);
    check("R3 cfg_done stays 0", int'(cfg_done), 0);
    force_hi = 1;
    wr(8'h19);
    check("R9 config during fault ignored", int'(cfg_done), 0);
    tick(40);
    check("R7 held low while pin reads high", int'(wdout_n), 0);
    force_hi = 0; force_lo = 1;
    tick(HOLD + 1);
    check("R7 released after hold", int'(wdout_n), 1);
    tick(50);
    check("R8 waits for pin high", int'(fault_act), 1);
    wr(8'h19);
    check("R9 write while waiting ignored", int'(cfg_done), 0);
    check("R9 no new pull", int'(wdout_n), 1);
    force_lo = 0;
    tick(1);
    check("R8 window starts on pin high", int'(fault_act), 0);
    wr(8'h19);
    check("R2 late configuring write", int'(cfg_done), 1);
    check("R2 window code 0", int'(win_sel), 0);
    tick(4); wr(8'hD9);
    check("R4 reconfigure attempt faults", int'(wdout_n), 0);
    check("R4 window unchanged", int'(win_sel), 0);
    recover("reconfig");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule